// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block takes one exception request at a time and performs the architectural side of exception entry for a 32-bit processor core. Each request carries an exception class, a refill (no-match) flag for translation faults, a coprocessor number for coprocessor-unusable faults, the PC of the faulting instruction and a flag telling whether that instruction sat in a branch delay slot. On the clock edge that accepts the request, the block updates its own status bits (exception level, error level, boot-vector select), its cause fields (5-bit code, branch-delay bit, coprocessor number), its saved exception PC and its saved error PC. It then presents the handler address with a one-cycle valid pulse.

The handler address is a base plus an offset. The base is the fixed boot vector area or a programmable base with its low ten bits cleared. The offset depends on the class, on whether a translation refill happens outside an active exception, on the boot-vector bit, and on the vectored-interrupt settings. Vectored interrupts can take their vector number from the highest enabled pending line or, in external-controller mode, from the raw pending field. A return strobe and a boot-vector clear strobe give the surrounding core the controls it needs to leave a handler and to move the vectors out of the boot area.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset, exception level and error level are 0, the boot-vector bit is 1, the handler valid output is 0 and the saved PCs, cause code, branch-delay bit and coprocessor field are 0. `handler_valid` is high exactly in the cycle after a cycle with `req_valid` high, and `handler_pc` holds the address computed from that request.
- R2: `req_class` encodes 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 14 floating point, 15 cache error, 16 NMI, 17 soft reset. Classes 0..15 write the cause codes 0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,30 into the 5-bit `cause_code` output.
- R3: The base is 0xBFC00200 when the boot-vector bit is 1, else `exc_base` with bits 9:0 cleared; the default offset is 0x180.
- R4: A TLB load or store with `req_refill` set, taken while exception level is 0, uses offset 0x000; with exception level 1 it uses 0x180.
- R5: An interrupt with `vec_enable` 0 uses 0x180. With `vec_enable` 1 it uses 0x200 when the boot-vector bit is 1 or `vec_spacing` is 0, else 0x200 + vector * (`vec_spacing` * 32).
- R6: With `ext_ctrl_mode` 0 the vector number is the index of the highest set bit of `irq_pending & irq_mask` (0 when none is set); with `ext_ctrl_mode` 1 it is `irq_pending` itself.
- R7: A cache error uses offset 0x100 when the boot-vector bit is 1 and 0x20000100 otherwise.
- R8: For classes 0..15, only when exception level is 0 does the block save the resume PC (`req_pc`, or `req_pc` − 4 when `req_in_delay` is 1) to `epc`, copy `req_in_delay` to `cause_bd` and set exception level; with exception level already 1, `epc` and `cause_bd` keep their values.
- R9: NMI and soft reset save the resume PC to `error_epc`, set error level and the boot-vector bit, clear `cause_bd` if exception level is 0, leave `cause_code` unchanged and jump to 0xBFC00000.
- R10: A coprocessor-unusable request writes `req_cp_num` into `cause_ce`; other classes leave it unchanged.
- R11: `ret_valid` without a request clears error level if it is set, else exception level; `boot_clear` clears the boot-vector bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_class | input | 5 | Exception class (encoding in R2) |
| req_refill | input | 1 | Translation fault had no matching entry |
| req_cp_num | input | 2 | Coprocessor number for coprocessor-unusable |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_delay | input | 1 | Faulting instruction was in a delay slot |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| vec_enable | input | 1 | Use the dedicated interrupt vector |
| vec_spacing | input | 5 | Vector spacing in 32-byte units |
| ext_ctrl_mode | input | 1 | Vector number comes from an external controller |
| exc_base | input | 32 | Programmable exception base |
| ret_valid | input | 1 | Exception return strobe |
| boot_clear | input | 1 | Clear the boot-vector bit |
| handler_valid | output | 1 | Handler address valid pulse |
| handler_pc | output | 32 | Handler address |
| epc | output | 32 | Saved exception PC |
| error_epc | output | 32 | Saved error PC |
| cause_code | output | 5 | Cause code field |
| cause_bd | output | 1 | Branch-delay bit |
| cause_ce | output | 2 | Coprocessor number field |
| st_exl | output | 1 | Exception level |
| st_erl | output | 1 | Error level |
| st_bev | output | 1 | Boot-vector select |

## Verification
The assertions take for granted that `req_class` never carries a value above 17 and that the request strobe is never held across two consecutive cycles by the core, so every entry is followed by an observable valid pulse before the next request. The stimulus drives each request for exactly one cycle, keeps the class inside the defined encoding, and issues return strobes only in cycles without a request, which keeps the order of entry and return unambiguous.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [4:0] {
    CLS_INT       = 5'd0,
    CLS_TLB_MOD   = 5'd1,
    CLS_TLB_LOAD  = 5'd2,
    CLS_TLB_STORE = 5'd3,
    CLS_ADR_LOAD  = 5'd4,
    CLS_ADR_STORE = 5'd5,
    CLS_IBUS      = 5'd6,
    CLS_DBUS      = 5'd7,
    CLS_SYSCALL   = 5'd8,
    CLS_BREAK     = 5'd9,
    CLS_RESV      = 5'd10,
    CLS_COP_UNUSE = 5'd11,
    CLS_OVERFLOW  = 5'd12,
    CLS_TRAP      = 5'd13,
    CLS_FPE       = 5'd14,
    CLS_CACHE_ERR = 5'd15,
    CLS_NMI       = 5'd16,
    CLS_SOFT_RST  = 5'd17
  } exc_class_e;

  localparam logic [XLEN-1:0] BOOT_GEN_BASE = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] BOOT_ERR_PC   = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] OFS_GENERAL   = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFS_REFILL    = 32'h0000_0000;
  localparam logic [XLEN-1:0] OFS_IRQ       = 32'h0000_0200;
  localparam logic [XLEN-1:0] OFS_CACHE_BT  = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_CACHE_RUN = 32'h2000_0100;

  function automatic logic [4:0] cause_of(exc_class_e c);
    case (c)
      CLS_FPE:       return 5'd15;
      CLS_CACHE_ERR: return 5'd30;
      default:       return (c <= CLS_TRAP) ? 5'(c) : 5'd0;
    endcase
  endfunction

  function automatic logic is_error_entry(exc_class_e c);
    return (c == CLS_NMI) || (c == CLS_SOFT_RST);
  endfunction
endpackage

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]         bits_i,
  output logic [$clog2(W)-1:0] idx_o
);
  localparam int unsigned IDX_W = $clog2(W);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (bits_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
  import exc_pkg::*;
#(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned SPC_W = 5
) (
  input  exc_class_e        cls_i,
  input  logic              refill_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              vec_en_i,
  input  logic [SPC_W-1:0]  spacing_i,
  input  logic [VEC_W-1:0]  vec_num_i,
  input  logic [XLEN-1:0]   base_i,
  output logic [XLEN-1:0]   target_o
);
  localparam int unsigned SLOT_SHIFT = 5;

  logic [XLEN-1:0] gen_base;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] slot_bytes;
  logic [XLEN-1:0] vec_ext;

  assign gen_base   = bev_i ? BOOT_GEN_BASE : (base_i & ~32'h0000_03FF);
  assign slot_bytes = XLEN'(spacing_i) << SLOT_SHIFT;
  assign vec_ext    = XLEN'(vec_num_i);

  always_comb begin
    offset = OFS_GENERAL;
    case (cls_i)
      CLS_TLB_LOAD, CLS_TLB_STORE:
        if (refill_i && !exl_i) offset = OFS_REFILL;
      CLS_INT:
        if (vec_en_i) begin
          if (bev_i || (spacing_i == '0)) offset = OFS_IRQ;
          else                             offset = OFS_IRQ + vec_ext * slot_bytes;
        end
      CLS_CACHE_ERR:
        offset = bev_i ? OFS_CACHE_BT : OFS_CACHE_RUN;
      default: ;
    endcase
  end

  assign target_o = is_error_entry(cls_i) ? BOOT_ERR_PC : (gen_base + offset);
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int unsigned IRQ_W = 8,
  parameter int unsigned SPC_W = 5,
  parameter int unsigned CP_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [4:0]        req_class,
  input  logic              req_refill,
  input  logic [CP_W-1:0]   req_cp_num,
  input  logic [31:0]       req_pc,
  input  logic              req_in_delay,
  input  logic [IRQ_W-1:0]  irq_pending,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              vec_enable,
  input  logic [SPC_W-1:0]  vec_spacing,
  input  logic              ext_ctrl_mode,
  input  logic [31:0]       exc_base,
  input  logic              ret_valid,
  input  logic              boot_clear,
  output logic              handler_valid,
  output logic [31:0]       handler_pc,
  output logic [31:0]       epc,
  output logic [31:0]       error_epc,
  output logic [4:0]        cause_code,
  output logic              cause_bd,
  output logic [CP_W-1:0]   cause_ce,
  output logic              st_exl,
  output logic              st_erl,
  output logic              st_bev
);
  localparam int unsigned IDX_W      = $clog2(IRQ_W);
  localparam logic [31:0] SLOT_BYTES = 32'd4;

  exc_class_e       cls;
  logic [IDX_W-1:0] prio_idx;
  logic [IRQ_W-1:0] vec_num;
  logic [31:0]      target;
  logic [31:0]      resume_pc;
  logic             err_entry;
  logic             upd_en;

  logic [31:0]      hpc_q, hpc_d, epc_q, epc_d, eepc_q, eepc_d;
  logic [4:0]       code_q, code_d;
  logic [CP_W-1:0]  ce_q, ce_d;
  logic             bd_q, bd_d, exl_q, exl_d, erl_q, erl_d, bev_q, bev_d;
  logic             vld_q;

  assign cls       = exc_class_e'(req_class);
  assign err_entry = is_error_entry(cls);
  assign resume_pc = req_in_delay ? (req_pc - SLOT_BYTES) : req_pc;

  exc_prio_enc #(.W(IRQ_W)) u_prio (
    .bits_i (irq_pending & irq_mask),
    .idx_o  (prio_idx)
  );

  assign vec_num = ext_ctrl_mode ? irq_pending : IRQ_W'(prio_idx);

  exc_vector_calc #(.VEC_W(IRQ_W), .SPC_W(SPC_W)) u_vec (
    .cls_i     (cls),
    .refill_i  (req_refill),
    .exl_i     (exl_q),
    .bev_i     (bev_q),
    .vec_en_i  (vec_enable),
    .spacing_i (vec_spacing),
    .vec_num_i (vec_num),
    .base_i    (exc_base),
    .target_o  (target)
  );

  assign upd_en = req_valid | ret_valid | boot_clear;

  // next-state logic
  always_comb begin
    hpc_d  = hpc_q;
    epc_d  = epc_q;
    eepc_d = eepc_q;
    code_d = code_q;
    ce_d   = ce_q;
    bd_d   = bd_q;
    exl_d  = exl_q;
    erl_d  = erl_q;
    bev_d  = bev_q;
    if (req_valid) begin
      hpc_d = target;
      if (err_entry) begin
        eepc_d = resume_pc;
        erl_d  = 1'b1;
        bev_d  = 1'b1;
        if (!exl_q) bd_d = 1'b0;
      end else begin
        if (!exl_q) begin
          epc_d = resume_pc;
          bd_d  = req_in_delay;
          exl_d = 1'b1;
        end
        code_d = cause_of(cls);
        if (cls == CLS_COP_UNUSE) ce_d = req_cp_num;
      end
    end else if (ret_valid) begin
      if (erl_q) erl_d = 1'b0;
      else       exl_d = 1'b0;
    end
    if (boot_clear && !(req_valid && err_entry)) bev_d = 1'b0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hpc_q  <= '0;
      epc_q  <= '0;
      eepc_q <= '0;
      code_q <= '0;
      ce_q   <= '0;
      bd_q   <= 1'b0;
      exl_q  <= 1'b0;
      erl_q  <= 1'b0;
      bev_q  <= 1'b1;
    end else begin
      vld_q <= req_valid;
      if (upd_en) begin
        hpc_q  <= hpc_d;
        epc_q  <= epc_d;
        eepc_q <= eepc_d;
        code_q <= code_d;
        ce_q   <= ce_d;
        bd_q   <= bd_d;
        exl_q  <= exl_d;
        erl_q  <= erl_d;
        bev_q  <= bev_d;
      end
    end
  end

  assign handler_valid = vld_q;
  assign handler_pc    = hpc_q;
  assign epc           = epc_q;
  assign error_epc     = eepc_q;
  assign cause_code    = code_q;
  assign cause_bd      = bd_q;
  assign cause_ce      = ce_q;
  assign st_exl        = exl_q;
  assign st_erl        = erl_q;
  assign st_bev        = bev_q;

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> handler_valid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !handler_valid);
  // R8
  epc_held_in_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && st_exl && !err_entry) |=> ($stable(epc) && $stable(cause_bd)));
  // R8
  level_set_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !err_entry) |=> st_exl);
  // R9
  error_entry_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && err_entry) |=> (st_erl && st_bev && handler_pc == 32'hBFC0_0000
                                  && $stable(cause_code)));
endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_refill, req_in_delay;
  logic [4:0]  req_class;
  logic [1:0]  req_cp_num;
  logic [31:0] req_pc;
  logic [7:0]  irq_pending, irq_mask;
  logic        vec_enable, ext_ctrl_mode, ret_valid, boot_clear;
  logic [4:0]  vec_spacing;
  logic [31:0] exc_base;
  logic        handler_valid, cause_bd, st_exl, st_erl, st_bev;
  logic [31:0] handler_pc, epc, error_epc;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit i_exc_entry_unit (
    .clk, .rst_n, .req_valid, .req_class, .req_refill, .req_cp_num, .req_pc,
    .req_in_delay, .irq_pending, .irq_mask, .vec_enable, .vec_spacing,
    .ext_ctrl_mode, .exc_base, .ret_valid, .boot_clear, .handler_valid,
    .handler_pc, .epc, .error_epc, .cause_code, .cause_bd, .cause_ce,
    .st_exl, .st_erl, .st_bev
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] cls, input logic [31:0] pc,
                      input logic dly, input logic refill, input logic [1:0] cp);
    @(negedge clk);
    req_valid = 1'b1; req_class = cls; req_pc = pc; req_in_delay = dly;
    req_refill = refill; req_cp_num = cp;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_return();
    @(negedge clk); ret_valid = 1'b1;
    @(negedge clk); ret_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset exl", 32'(st_exl), 0);
    chk("R1 reset erl", 32'(st_erl), 0);
    chk("R1 reset bev", 32'(st_bev), 1);
    chk("R1 reset valid", 32'(handler_valid), 0);
    chk("R1 reset epc", epc, 0);
    chk("R1 reset code", 32'(cause_code), 0);
    @(negedge clk); boot_clear = 1'b1;
    @(negedge clk); boot_clear = 1'b0;
    chk("R11 bev cleared", 32'(st_bev), 0);
  endtask

  task automatic t_syscall_nested();
    send(5'd8, 32'h1000, 1'b0, 1'b0, 2'd0);
    chk("R1 valid pulse", 32'(handler_valid), 1);
    chk("R3 general vector", handler_pc, 32'h8000_1180);
    chk("R8 epc saved", epc, 32'h1000);
    chk("R2 syscall code", 32'(cause_code), 8);
    chk("R8 exl set", 32'(st_exl), 1);
    @(negedge clk);
    chk("R1 valid drops", 32'(handler_valid), 0);
    send(5'd9, 32'h2000, 1'b1, 1'b0, 2'd0);
    chk("R8 epc kept", epc, 32'h1000);
    chk("R8 bd kept", 32'(cause_bd), 0);
    chk("R2 break code", 32'(cause_code), 9);
    do_return();
    chk("R11 return clears exl", 32'(st_exl), 0);
  endtask

  task automatic t_refill();
    send(5'd2, 32'h3004, 1'b1, 1'b1, 2'd0);
    chk("R4 load refill", handler_pc, 32'h8000_1000);
    chk("R8 delay resume", epc, 32'h3000);
    chk("R8 bd set", 32'(cause_bd), 1);
    chk("R2 tlb load code", 32'(cause_code), 2);
    do_return();
    send(5'd3, 32'h3100, 1'b0, 1'b1, 2'd0);
    chk("R4 store refill", handler_pc, 32'h8000_1000);
    chk("R2 tlb store code", 32'(cause_code), 3);
    send(5'd3, 32'h3200, 1'b0, 1'b1, 2'd0);
    chk("R4 refill under exl", handler_pc, 32'h8000_1180);
    do_return();
  endtask

  task automatic t_irq();
    vec_enable = 1'b1; vec_spacing = 5'd1; irq_pending = 8'h2C; irq_mask = 8'h0F;
    send(5'd0, 32'h4000, 1'b0, 1'b0, 2'd0);
    chk("R6 priority vector", handler_pc, 32'h8000_1260);
    chk("R2 irq code", 32'(cause_code), 0);
    do_return();
    ext_ctrl_mode = 1'b1; vec_spacing = 5'd2; irq_pending = 8'h05;
    send(5'd0, 32'h4000, 1'b0, 1'b0, 2'd0);
    chk("R6 external vector", handler_pc, 32'h8000_1340);
    do_return();
    ext_ctrl_mode = 1'b0; irq_pending = 8'h80; irq_mask = 8'h00;
    send(5'd0, 32'h4000, 1'b0, 1'b0, 2'd0);
    chk("R6 nothing enabled", handler_pc, 32'h8000_1200);
    do_return();
    vec_spacing = 5'd0;
    send(5'd0, 32'h4000, 1'b0, 1'b0, 2'd0);
    chk("R5 zero spacing", handler_pc, 32'h8000_1200);
    do_return();
    vec_enable = 1'b0; vec_spacing = 5'd1;
    send(5'd0, 32'h4000, 1'b0, 1'b0, 2'd0);
    chk("R5 not vectored", handler_pc, 32'h8000_1180);
    do_return();
  endtask

  task automatic t_cop_cache();
    send(5'd11, 32'h4400, 1'b0, 1'b0, 2'd2);
    chk("R10 ce field", 32'(cause_ce), 2);
    chk("R2 cop code", 32'(cause_code), 11);
    do_return();
    send(5'd14, 32'h4500, 1'b0, 1'b0, 2'd1);
    chk("R10 ce unchanged", 32'(cause_ce), 2);
    chk("R2 fpe code", 32'(cause_code), 15);
    do_return();
    send(5'd15, 32'h4600, 1'b0, 1'b0, 2'd0);
    chk("R7 cache run vector", handler_pc, 32'hA000_1100);
    chk("R2 cache code", 32'(cause_code), 30);
    do_return();
  endtask

  task automatic t_nmi();
    send(5'd16, 32'h5000, 1'b1, 1'b0, 2'd0);
    chk("R9 nmi vector", handler_pc, 32'hBFC0_0000);
    chk("R9 error epc", error_epc, 32'h4FFC);
    chk("R9 erl set", 32'(st_erl), 1);
    chk("R9 bev set", 32'(st_bev), 1);
    chk("R9 code kept", 32'(cause_code), 30);
    chk("R9 bd cleared", 32'(cause_bd), 0);
    chk("R9 epc untouched", epc, 32'h4600);
    do_return();
    chk("R11 return clears erl", 32'(st_erl), 0);
  endtask

  task automatic t_boot_vectors();
    send(5'd8, 32'h5100, 1'b0, 1'b0, 2'd0);
    chk("R3 boot general", handler_pc, 32'hBFC0_0380);
    do_return();
    send(5'd15, 32'h5200, 1'b0, 1'b0, 2'd0);
    chk("R7 cache boot vector", handler_pc, 32'hBFC0_0300);
    do_return();
    vec_enable = 1'b1; irq_pending = 8'h02; irq_mask = 8'hFF;
    send(5'd0, 32'h5300, 1'b0, 1'b0, 2'd0);
    chk("R5 boot irq", handler_pc, 32'hBFC0_0400);
    do_return();
    send(5'd2, 32'h5400, 1'b0, 1'b1, 2'd0);
    chk("R4 boot refill", handler_pc, 32'hBFC0_0200);
    do_return();
    send(5'd17, 32'h6000, 1'b0, 1'b0, 2'd0);
    chk("R9 soft reset vector", handler_pc, 32'hBFC0_0000);
    chk("R9 soft reset epc", error_epc, 32'h6000);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_class = '0; req_refill = 1'b0;
    req_cp_num = '0; req_pc = '0; req_in_delay = 1'b0; irq_pending = '0;
    irq_mask = '0; vec_enable = 1'b0; vec_spacing = '0; ext_ctrl_mode = 1'b0;
    exc_base = 32'h8000_1234; ret_valid = 1'b0; boot_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_syscall_nested();
    t_refill();
    t_irq();
    t_cop_cache();
    t_nmi();
    t_boot_vectors();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule